// File: doc/BRIEF.md
# Breakpoint Halt Controller

This block turns a manual breakpoint request into either a processor halt or a debug interrupt. The choice is made at run time by a single mode input. In halt mode, a rising edge on the breakpoint input raises a halt request at once. The processor does not become halted until the core reports that the instruction in flight has completed. While halted, the 8-bit processor-status/debug-data bus carries a fixed halt code on every cycle instead of the core's own status. In interrupt mode, the same edge produces a one-cycle debug-interrupt pulse and no halt.

A resume command ends a pending or active halt. It also hands the status bus back to the core. A second input decides whether pending interrupts are forwarded to the core while it is halted. A constant hardware revision code is presented on its own output.

Every pin is a plain control or status level sampled on the rising clock edge. There is no data stream and no valid/ready handshake, so no back-pressure rules apply. The breakpoint input must already be synchronous to the clock.

Top module: `brk_halt_ctrl`

## Requirements
- R1: After reset, `halt_req_o` and `dbg_irq_o` are 0 and `status_o` equals `core_status_i`.
- R2: With `brk_irq_mode_i` = 0 and no halt pending or active, a 0-to-1 change of `brk_req_i` sets `halt_req_o` to 1 after the next clock edge.
- R3: A pending halt becomes an active halt only on an edge where `insn_done_i` is 1. Until then `status_o` keeps following `core_status_i`. `insn_done_i` has no effect when no halt is pending.
- R4: While the halt is active, `status_o` is 8'h0F on every cycle, whatever `core_status_i` carries.
- R5: With `brk_irq_mode_i` = 1 and no halt pending or active, a 0-to-1 change of `brk_req_i` makes `dbg_irq_o` 1 for exactly one cycle after the next edge, and `halt_req_o` stays 0.
- R6: A breakpoint input that stays at 1 produces no further interrupt pulse or halt. Only a new rising edge counts.
- R7: A rising edge of `brk_req_i` that arrives while a halt is pending or active is ignored. It produces no interrupt pulse and no second halt, in either mode.
- R8: `resume_i` = 1 at an edge ends a pending or active halt. From the next cycle, `halt_req_o` is 0 and `status_o` equals `core_status_i`.
- R9: `irq_service_o` follows `irq_pending_i`, except that it is 0 while the halt is active and `ign_pend_irq_i` = 1.
- R10: `hw_rev_o` always reads 4'hB (binary 1011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req_i | input | 1 | Manual breakpoint request (synchronous level) |
| insn_done_i | input | 1 | Core strobe: current instruction has completed |
| brk_irq_mode_i | input | 1 | 1 = breakpoint raises a debug interrupt, 0 = breakpoint halts |
| ign_pend_irq_i | input | 1 | 1 = hold off pending interrupts while halted |
| resume_i | input | 1 | Resume command |
| irq_pending_i | input | 1 | Interrupt pending from the interrupt controller |
| core_status_i | input | 8 | Core's normal processor status |
| halt_req_o | output | 1 | Halt pending or active |
| dbg_irq_o | output | 1 | One-cycle debug-interrupt request |
| irq_service_o | output | 1 | Interrupt forwarded to the core for service |
| status_o | output | 8 | Processor-status/debug-data bus |
| hw_rev_o | output | 4 | Hardware revision code |

## Verification
The breakpoint input is exercised with the following patterns, and each one separates a different fault:
- A clean edge in halt mode, with the instruction-complete strobe delayed by several cycles. This separates the pending phase from the halted phase.
- An edge in interrupt mode followed by a long hold. This tells a true edge detector from a level-sensitive one.
- Edges injected while a halt is pending and while it is halted, with the mode bit flipped to interrupt. These show whether such edges are really ignored.

Resume is applied both during the pending phase and during the halted phase. Pending interrupts are offered with the ignore bit set and cleared, both inside and outside the halt, so the gating is shown to depend on both conditions.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned REV_W  = 4;
  localparam logic [STAT_W-1:0] HALT_CODE = 8'h0F;
  localparam logic [REV_W-1:0]  HW_REV    = 4'hB;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_HALT = 2'd2
  } halt_state_t;
endpackage

// File: rtl/brk_edge.sv
module brk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/brk_halt_fsm.sv
module brk_halt_fsm
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_i,
  input  logic        irq_mode_i,
  input  logic        insn_done_i,
  input  logic        resume_i,
  output halt_state_t state_o,
  output logic        irq_pulse_o
);
  halt_state_t state_q, state_d;
  logic        irq_d;

  always_comb begin
    state_d = state_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (rise_i) begin
          if (irq_mode_i) irq_d   = 1'b1;
          else            state_d = ST_PEND;
        end
      end
      ST_PEND: begin
        if (resume_i)         state_d = ST_RUN;
        else if (insn_done_i) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (resume_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      irq_pulse_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      irq_pulse_o <= irq_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/brk_status_mux.sv
module brk_status_mux
  import brk_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] CODE = HALT_CODE
) (
  input  logic         halted_i,
  input  logic [W-1:0] core_status_i,
  output logic [W-1:0] status_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign status_o[b] = halted_i ? CODE[b] : core_status_i[b];
  end
endmodule

// File: rtl/brk_halt_ctrl.sv
module brk_halt_ctrl
  import brk_pkg::*;
#(
  parameter int unsigned SW = STAT_W,
  parameter int unsigned RW = REV_W,
  parameter logic [SW-1:0] CODE = HALT_CODE,
  parameter logic [RW-1:0] REV  = HW_REV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_req_i,
  input  logic          insn_done_i,
  input  logic          brk_irq_mode_i,
  input  logic          ign_pend_irq_i,
  input  logic          resume_i,
  input  logic          irq_pending_i,
  input  logic [SW-1:0] core_status_i,
  output logic          halt_req_o,
  output logic          dbg_irq_o,
  output logic          irq_service_o,
  output logic [SW-1:0] status_o,
  output logic [RW-1:0] hw_rev_o
);
  logic        rise;
  halt_state_t state;
  logic        halted;

  brk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (brk_req_i),
    .rise_o  (rise)
  );

  brk_halt_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .irq_mode_i  (brk_irq_mode_i),
    .insn_done_i (insn_done_i),
    .resume_i    (resume_i),
    .state_o     (state),
    .irq_pulse_o (dbg_irq_o)
  );

  assign halted     = (state == ST_HALT);
  assign halt_req_o = (state != ST_RUN);

  brk_status_mux #(.W(SW), .CODE(CODE)) u_mux (
    .halted_i      (halted),
    .core_status_i (core_status_i),
    .status_o      (status_o)
  );

  assign irq_service_o = irq_pending_i & ~(halted & ign_pend_irq_i);
  assign hw_rev_o      = REV;
endmodule

// File: rtl/brk_halt_chk.sv
module brk_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_req_i,
  input logic       brk_irq_mode_i,
  input logic       resume_i,
  input logic       irq_pending_i,
  input logic [7:0] core_status_i,
  input logic       halt_req_o,
  input logic       dbg_irq_o,
  input logic       irq_service_o,
  input logic [7:0] status_o,
  input logic [3:0] hw_rev_o
);
  // R4: any departure from the core status must be the halt code during a halt
  a_r4_halt_code: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != core_status_i) |-> (status_o == 8'h0F && halt_req_o));

  // R5: the interrupt request lasts a single cycle
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_o |=> !dbg_irq_o);

  // R7: no interrupt while a halt is pending or active
  a_r7_no_irq_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req_o |-> !dbg_irq_o);

  // R2: an edge in halt mode from the run state raises a halt request
  a_r2_halt_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_req_i) && !brk_irq_mode_i && !halt_req_o) |=> halt_req_o);

  // R8: resume clears the halt request
  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_i && halt_req_o) |=> !halt_req_o);

  // R9: service is never granted without a pending interrupt
  a_r9_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_service_o |-> irq_pending_i);

  // R10: constant revision code
  a_r10_rev: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rev_o == 4'hB);
endmodule

bind brk_halt_ctrl brk_halt_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .brk_req_i      (brk_req_i),
  .brk_irq_mode_i (brk_irq_mode_i),
  .resume_i       (resume_i),
  .irq_pending_i  (irq_pending_i),
  .core_status_i  (core_status_i),
  .halt_req_o     (halt_req_o),
  .dbg_irq_o      (dbg_irq_o),
  .irq_service_o  (irq_service_o),
  .status_o       (status_o),
  .hw_rev_o       (hw_rev_o)
);

// File: tb/brk_halt_ctrl_tb.sv
`timescale 1ns/1ps
module brk_halt_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       brk = 1'b0, done = 1'b0, mode = 1'b0, ign = 1'b0, res = 1'b0, pend = 1'b0;
  logic [7:0] core = 8'h00;
  logic       halt_o, irq_o, svc_o;
  logic [7:0] stat_o;
  logic [3:0] rev_o;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] st;
    logic       h;
    logic       i;
    logic       s;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  brk_halt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .brk_req_i(brk), .insn_done_i(done),
    .brk_irq_mode_i(mode), .ign_pend_irq_i(ign), .resume_i(res),
    .irq_pending_i(pend), .core_status_i(core),
    .halt_req_o(halt_o), .dbg_irq_o(irq_o), .irq_service_o(svc_o),
    .status_o(stat_o), .hw_rev_o(rev_o)
  );

  task automatic check(input exp_t e);
    tests++;
    if (stat_o !== e.st || halt_o !== e.h || irq_o !== e.i || svc_o !== e.s || rev_o !== 4'hB) begin
      fails++;
      $display("FAIL %s: got st=%h h=%b i=%b s=%b rev=%h, exp st=%h h=%b i=%b s=%b rev=b",
               e.tag, stat_o, halt_o, irq_o, svc_o, rev_o, e.st, e.h, e.i, e.s);
    end
  endtask

  // monitor: compares one expected item after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) check(q.pop_front());
  end

  // driver: applies inputs, pushes the values expected after the next edge
  task automatic cyc(input logic b, input logic d, input logic m, input logic ig,
                     input logic p, input logic r, input logic [7:0] c,
                     input logic [7:0] est, input logic eh, input logic ei,
                     input logic es, input string tag);
    exp_t e;
    @(negedge clk);
    brk = b; done = d; mode = m; ign = ig; pend = p; res = r; core = c;
    e.st = est; e.h = eh; e.i = ei; e.s = es; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    fork
      begin
        #200000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    core = 8'h21;
    repeat (3) @(negedge clk);
    begin
      exp_t e;
      e.st = 8'h21; e.h = 0; e.i = 0; e.s = 0; e.tag = "R1 reset";
      check(e);
    end
    rst_n = 1'b1;
    //   brk done mode ign pend res core   st     h  i  s
    cyc(0, 0, 0, 0, 0, 0, 8'h21, 8'h21, 0, 0, 0, "R1 idle");
    cyc(0, 1, 0, 0, 0, 0, 8'h22, 8'h22, 0, 0, 0, "R3 done without pending");
    cyc(1, 0, 0, 0, 0, 0, 8'h23, 8'h23, 1, 0, 0, "R2 halt request on edge");
    cyc(1, 0, 0, 0, 1, 0, 8'h24, 8'h24, 1, 0, 1, "R3 pending keeps core status");
    cyc(0, 0, 1, 0, 0, 0, 8'h25, 8'h25, 1, 0, 0, "R7 setup");
    cyc(1, 0, 1, 0, 0, 0, 8'h26, 8'h26, 1, 0, 0, "R7 edge while pending ignored");
    cyc(1, 1, 0, 0, 0, 0, 8'h27, 8'h0F, 1, 0, 0, "R3 halt on instruction done");
    cyc(1, 0, 0, 0, 0, 0, 8'h33, 8'h0F, 1, 0, 0, "R4 halt code held");
    cyc(0, 0, 0, 1, 1, 0, 8'h34, 8'h0F, 1, 0, 0, "R9 pending blocked while halted");
    cyc(1, 0, 1, 0, 1, 0, 8'h35, 8'h0F, 1, 0, 1, "R7 edge while halted ignored R9 passes");
    cyc(1, 0, 1, 1, 1, 1, 8'h36, 8'h36, 0, 0, 1, "R8 resume from halt");
    cyc(1, 0, 1, 1, 1, 0, 8'h37, 8'h37, 0, 0, 1, "R6 held input no new pulse");
    cyc(0, 0, 1, 0, 0, 0, 8'h38, 8'h38, 0, 0, 0, "R5 setup");
    cyc(1, 0, 1, 0, 0, 0, 8'h39, 8'h39, 0, 1, 0, "R5 interrupt pulse");
    cyc(1, 0, 1, 0, 0, 0, 8'h3A, 8'h3A, 0, 0, 0, "R5 pulse is one cycle");
    cyc(1, 1, 1, 0, 0, 0, 8'h3B, 8'h3B, 0, 0, 0, "R6 held no halt");
    cyc(0, 0, 0, 0, 0, 0, 8'h40, 8'h40, 0, 0, 0, "R2 setup");
    cyc(1, 0, 0, 0, 0, 0, 8'h41, 8'h41, 1, 0, 0, "R2 second halt request");
    cyc(1, 0, 0, 0, 0, 1, 8'h42, 8'h42, 0, 0, 0, "R8 resume cancels pending");
    cyc(1, 1, 0, 0, 0, 0, 8'h43, 8'h43, 0, 0, 0, "R6 held no re-halt");
    cyc(0, 0, 0, 0, 0, 0, 8'h44, 8'h44, 0, 0, 0, "R1 quiet");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule